// File: doc/BRIEF.md
# Extensible Stack Pointer Unit

This unit keeps the stack pointer of an 8-bit processor core and turns each push or pop strobe into a physical stack address with a memory-select flag. In its default mode the pointer is eight bits wide and every stack access falls inside the 256-byte internal data RAM. The pointer wraps around inside that RAM.

When the extend input is high, three more bits sit above the low byte and form an 11-bit pointer. Once the pointer passes 00FFH, stack traffic moves on to the XRAM region from 0100H up to 07FFH. The lowest 256 bytes of XRAM never hold stack data.

Software reaches both pointer bytes through two special-function-register addresses. The memories themselves are outside this unit. The unit only produces the address, the select flag and the direction of the access in the same cycle as the strobe, and it updates the pointer at the following clock edge.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the low pointer byte reads 07H at SFR address 81H and the high extension reads 00H at SFR address B7H.
- R2: A push pre-increments: in the strobe cycle stk_addr shows the incremented pointer, stk_wr is 1 and stk_valid is 1, and after the clock edge the pointer holds that value. The first push after reset therefore addresses 008H.
- R3: A pop post-decrements: in the strobe cycle stk_addr shows the current pointer, stk_wr is 0 and stk_valid is 1, and after the clock edge the pointer is one lower.
- R4: With ext_en low, only the low byte moves and it wraps between FFH and 00H. stk_addr[10:8] is 0, stk_xram is 0, and the stored high extension is left unchanged.
- R5: With ext_en high the 11-bit pointer counts through 00FFH into 0100H. stk_xram is 1 exactly when a valid access has an address of 0100H or above.
- R6: With ext_en high, a pop at 0100H reads XRAM and leaves the pointer at 00FFH, so the next pop reads internal RAM.
- R7: With ext_en high, a push from 07FFH addresses 0000H in internal RAM.
- R8: When push and pop are both high, only the push takes effect.
- R9: An SFR write to 81H loads the low byte. An SFR write to B7H loads only the three low data bits into the extension. Reads of B7H return 0 in bits 7..3. Reads of any other SFR address return 00H, and writes to other addresses change nothing.
- R10: An SFR write in a cycle that also has a push or pop strobe is discarded, and the stack operation updates the pointer.
- R11: With no strobe, stk_valid, stk_wr and stk_xram are 0, and the pointer changes only through an SFR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| ext_en | input | 1 | 1 selects the 11-bit pointer, 0 the 8-bit pointer |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for sfr_addr |
| stk_addr | output | 11 | Physical stack address of the current access |
| stk_xram | output | 1 | 1 when the access targets XRAM, 0 for internal RAM |
| stk_wr | output | 1 | 1 for a push (write), 0 for a pop (read) |
| stk_valid | output | 1 | 1 when an access is issued this cycle |

## Verification
The bench targets the places where the pointer crosses a boundary:
- the FFH to 00H wrap in byte mode, where a design that carried into the extension would let the stack escape into XRAM;
- the 00FFH to 0100H step and the borrow back from 0100H, where a wrong select would place bytes in the wrong memory or break pop ordering;
- the 07FFH to 0000H wrap.

It also hits the same-cycle conflicts: push against pop, and a stack strobe against an SFR write. An inverted priority there would show up as a wrong address or a wrong readback on the next cycle. Readback of the extension register checks that bits 7..3 stay zero.

// File: rtl/stkptr_unit.sv
module stkptr_unit #(
  parameter int LOW_W = 8,
  parameter int EXT_W = 3,
  parameter logic [7:0] SPL_ADDR = 8'h81,
  parameter logic [7:0] SPH_ADDR = 8'hB7,
  parameter logic [7:0] LOW_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic       ext_en,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  output logic [LOW_W+EXT_W-1:0] stk_addr,
  output logic       stk_xram,
  output logic       stk_wr,
  output logic       stk_valid
);
  localparam int PTR_W = LOW_W + EXT_W;

  logic [LOW_W-1:0] spl_q;
  logic [EXT_W-1:0] sph_q;

  logic [PTR_W-1:0] full, full_inc, full_dec;
  logic [LOW_W-1:0] low_inc, low_dec;
  logic [PTR_W-1:0] nxt_push, nxt_pop;

  assign full     = {sph_q, spl_q};
  assign full_inc = full + 1'b1;
  assign full_dec = full - 1'b1;
  assign low_inc  = spl_q + 1'b1;
  assign low_dec  = spl_q - 1'b1;

  assign nxt_push = ext_en ? full_inc : {sph_q, low_inc};
  assign nxt_pop  = ext_en ? full_dec : {sph_q, low_dec};

  assign stk_valid = push | pop;
  assign stk_wr    = push;
  assign stk_addr  = push ? (ext_en ? full_inc : {{EXT_W{1'b0}}, low_inc})
                   : pop  ? (ext_en ? full     : {{EXT_W{1'b0}}, spl_q})
                   : '0;
  assign stk_xram  = stk_valid & ext_en & (|stk_addr[PTR_W-1:LOW_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spl_q <= LOW_RESET[LOW_W-1:0];
      sph_q <= '0;
    end else if (push) begin
      {sph_q, spl_q} <= nxt_push;
    end else if (pop) begin
      {sph_q, spl_q} <= nxt_pop;
    end else if (sfr_wr) begin
      if (sfr_addr == SPL_ADDR) spl_q <= sfr_wdata[LOW_W-1:0];
      if (sfr_addr == SPH_ADDR) sph_q <= sfr_wdata[EXT_W-1:0];
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == SPL_ADDR) sfr_rdata = spl_q;
    else if (sfr_addr == SPH_ADDR) sfr_rdata = {{(8-EXT_W){1'b0}}, sph_q};
  end
endmodule

module stkptr_unit_chk #(
  parameter int LOW_W = 8,
  parameter int EXT_W = 3,
  parameter logic [7:0] SPH_ADDR = 8'hB7
) (
  input logic clk,
  input logic rst_n,
  input logic push,
  input logic pop,
  input logic ext_en,
  input logic sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_rdata,
  input logic [LOW_W+EXT_W-1:0] sp,
  input logic [LOW_W+EXT_W-1:0] stk_addr,
  input logic stk_xram,
  input logic stk_wr,
  input logic stk_valid
);
  localparam int PTR_W = LOW_W + EXT_W;
  localparam logic [PTR_W-1:0] TOP = '1;
  localparam logic [PTR_W-1:0] XBASE = PTR_W'(1) << LOW_W;

  // R2
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp[LOW_W-1:0] == $past(stk_addr[LOW_W-1:0]));
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp[LOW_W-1:0] == LOW_W'($past(stk_addr[LOW_W-1:0]) - 1'b1));
  // R4
  byte_mode_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && stk_valid) |-> (!stk_xram && stk_addr[PTR_W-1:LOW_W] == '0));
  // R4
  byte_mode_ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && stk_valid) |=> $stable(sp[PTR_W-1:LOW_W]));
  // R6
  borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && pop && !push && sp == XBASE) |=> sp == XBASE - 1'b1);
  // R7
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && push && sp == TOP) |-> (stk_addr == '0 && !stk_xram));
  // R8
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |-> stk_wr);
  // R9
  ext_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SPH_ADDR) |-> sfr_rdata[7:EXT_W] == '0);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !sfr_wr) |=> $stable(sp));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |-> (!stk_valid && !stk_wr && !stk_xram));
endmodule

bind stkptr_unit stkptr_unit_chk #(.LOW_W(LOW_W), .EXT_W(EXT_W), .SPH_ADDR(SPH_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .ext_en(ext_en),
  .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_rdata(sfr_rdata),
  .sp({sph_q, spl_q}), .stk_addr(stk_addr), .stk_xram(stk_xram),
  .stk_wr(stk_wr), .stk_valid(stk_valid)
);

// File: tb/stkptr_unit_test.sv
module stkptr_unit_test;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, ext_en = 0, sfr_wr = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic [10:0] stk_addr;
  logic stk_xram, stk_wr, stk_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_spl;
  logic [2:0] m_sph;

  always #10 clk = ~clk;

  stkptr_unit uut (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .ext_en(ext_en),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .stk_addr(stk_addr), .stk_xram(stk_xram),
    .stk_wr(stk_wr), .stk_valid(stk_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_addr(logic p, logic q, logic e);
    logic [10:0] f = {m_sph, m_spl};
    if (p) return e ? f + 11'd1 : {3'b000, m_spl + 8'd1};
    if (q) return e ? f : {3'b000, m_spl};
    return 11'd0;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == 8'h81) return m_spl;
    if (a == 8'hB7) return {5'b0, m_sph};
    return 8'h00;
  endfunction

  function automatic string op_tag(logic p, logic q, logic e);
    logic [10:0] f = {m_sph, m_spl};
    if (p && q) return "R8";
    if (p) begin
      if (e && f == 11'h0FF) return "R5";
      if (e && f == 11'h7FF) return "R7";
      if (!e) return (m_spl == 8'hFF) ? "R4" : "R2";
      return "R2";
    end
    if (q) return (e && f == 11'h100) ? "R6" : "R3";
    return "R11";
  endfunction

  task automatic step(logic p, logic q, logic e, logic w, logic [7:0] a, logic [7:0] d);
    logic [10:0] ea;
    string t;
    @(negedge clk);
    push = p; pop = q; ext_en = e; sfr_wr = w; sfr_addr = a; sfr_wdata = d;
    #2;
    ea = exp_addr(p, q, e);
    t = op_tag(p, q, e);
    chk(t, stk_addr, ea);
    chk(t, stk_xram, (p | q) & e & (ea >= 11'h100));
    chk(t, stk_wr, p);
    chk(t, stk_valid, p | q);
    chk(((p | q) && w) ? "R10" : "R9", sfr_rdata, exp_rd(a));
    @(posedge clk);
    if (p) begin
      if (e) {m_sph, m_spl} = {m_sph, m_spl} + 11'd1; else m_spl = m_spl + 8'd1;
    end else if (q) begin
      if (e) {m_sph, m_spl} = {m_sph, m_spl} - 11'd1; else m_spl = m_spl - 8'd1;
    end else if (w) begin
      if (a == 8'h81) m_spl = d;
      if (a == 8'hB7) m_sph = d[2:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_spl = 8'h07; m_sph = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset readback
    @(negedge clk); sfr_addr = 8'h81; #2; chk("R1", sfr_rdata, 8'h07);
    sfr_addr = 8'hB7; #2; chk("R1", sfr_rdata, 8'h00);
    // R2 first push lands at 08H
    step(1, 0, 0, 0, 8'h81, 0);
    chk("R2", m_spl, 8'h08);
    step(0, 0, 0, 0, 8'h81, 0);
    // R4 byte-mode wrap with extension preset
    step(0, 0, 0, 1, 8'hB7, 8'hFD);
    step(0, 0, 0, 0, 8'hB7, 0);
    step(0, 0, 0, 1, 8'h81, 8'hFF);
    step(1, 0, 0, 0, 8'hB7, 0);
    step(0, 1, 0, 0, 8'h81, 0);
    // R9 unrelated address
    step(0, 0, 0, 1, 8'h42, 8'h55);
    step(0, 0, 0, 0, 8'h42, 0);
    // R5 / R6 crossing into XRAM and back
    step(0, 0, 1, 1, 8'hB7, 8'h00);
    step(0, 0, 1, 1, 8'h81, 8'hFE);
    step(1, 0, 1, 0, 8'h81, 0);
    step(1, 0, 1, 0, 8'hB7, 0);
    step(1, 0, 1, 0, 8'hB7, 0);
    step(0, 1, 1, 0, 8'h81, 0);
    step(0, 1, 1, 0, 8'h81, 0);
    step(0, 1, 1, 0, 8'hB7, 0);
    // R7 top wrap
    step(0, 0, 1, 1, 8'hB7, 8'h07);
    step(0, 0, 1, 1, 8'h81, 8'hFF);
    step(1, 0, 1, 0, 8'hB7, 0);
    step(0, 1, 1, 0, 8'h81, 0);
    // R8 push over pop, R10 op over SFR write
    step(1, 1, 1, 0, 8'h81, 0);
    step(1, 0, 0, 1, 8'h81, 8'hAA);
    step(0, 1, 1, 1, 8'hB7, 8'h05);
    step(0, 0, 0, 0, 8'h81, 0);
    step(0, 0, 0, 0, 8'hB7, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic p, q, e, w;
      logic [7:0] a, d;
      int r;
      r = $urandom_range(99);
      p = r < 40;
      q = (r >= 35) && (r < 75);
      e = (i / 500) % 2 == 1;
      w = $urandom_range(99) < 25;
      r = $urandom_range(2);
      a = (r == 0) ? 8'h81 : (r == 1) ? 8'hB7 : 8'($urandom);
      d = (($urandom_range(3)) == 0) ? 8'hFF : 8'($urandom);
      step(p, q, e, w, a, d);
    end
    @(negedge clk);
    push = 0; pop = 0; sfr_wr = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule